// File: doc/BRIEF.md
# Parallel Display Bus Write Engine

This block sends command and pixel/parameter words to a display controller over a parallel display bus. One engine serves two strobe conventions. The first is a write-strobe bus, where an active-low write line pulses per word and the read line stays idle. The second is an enable-strobe bus, where a read/write select is held at write and a high enable pulse latches each word. A four-bit mode code picks the convention and a data width of 8, 9 or 16 lanes.

The host offers one word at a time on a valid/ready interface. Each word is tagged as a command or as data, and carries a flag that marks the last word of a transaction. Chip select goes low when the first word is accepted and stays low until the final word has finished its hold phase. Setup, strobe width and hold are each set in clock cycles by configuration inputs, so a slow panel can be met without changing the core clock.

Top module: `pbus_wr_engine`

## Requirements
- R1: In reset and right after it, `bus_cs_n` is 1, `bus_ctl_a` is 1, `bus_ctl_b` is 1, `bus_dc` is 1, `bus_data` is 0, and `in_ready` is 1 when `cfg_mode` holds a valid code.
- R2: Mode codes decode as follows: 0x6, 0x7 and 0x8 select the write-strobe bus at 16, 9 and 8 lanes; 0x3, 0x4 and 0x5 select the enable-strobe bus at 16, 9 and 8 lanes. With any other code, `in_ready` stays 0, no word is taken and `bus_cs_n` stays 1.
- R3: `bus_dc` is 0 while a word sent with `in_cmd`=1 is on the bus and 1 while a word sent with `in_cmd`=0 is on the bus.
- R4: On the write-strobe bus, `bus_ctl_a` is the write strobe: it goes low once per word. `bus_ctl_b` is the read strobe and stays 1 at all times.
- R5: On the enable-strobe bus, `bus_ctl_a` is the read/write select and is 0 whenever `bus_cs_n` is 0 (1 otherwise). `bus_ctl_b` is the enable and goes high once per word.
- R6: `bus_cs_n` goes low in the cycle after the first word is accepted. It stays low across all later words, including the idle cycles between them. It returns to 1 only after the hold phase of a word sent with `in_last`=1.
- R7: After acceptance, the word sits on `bus_data` for `cfg_setup`+1 cycles with the strobe inactive. The strobe is then active for `cfg_pulse`+1 cycles, and inactive again for `cfg_hold`+1 cycles. `bus_data` does not change during any of these phases.
- R8: At 8-lane width, `bus_data[15:8]` is 0 and `bus_data[7:0]` carries the low byte of the word. At 9-lane width, `bus_data[15:9]` is 0 and `bus_data[8:0]` carries the low nine bits. At 16-lane width, all bits of the word are driven.
- R9: `in_ready` is 1 only while no word is in flight. A handshake (`in_valid` and `in_ready` both 1 at a rising edge) takes exactly one word. `in_ready` is 0 from the cycle after a handshake until the end of that word's hold phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 4 | Bus convention and width code |
| cfg_setup | input | TW | Setup cycles minus one |
| cfg_pulse | input | TW | Strobe-active cycles minus one |
| cfg_hold | input | TW | Hold cycles minus one |
| in_valid | input | 1 | Host offers a word |
| in_ready | output | 1 | Engine can take a word |
| in_cmd | input | 1 | Offered word is a command |
| in_last | input | 1 | Offered word ends the transaction |
| in_word | input | 16 | Offered word |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_dc | output | 1 | Low for command, high for data |
| bus_ctl_a | output | 1 | Write strobe, or read/write select |
| bus_ctl_b | output | 1 | Read strobe, or enable |
| bus_data | output | 16 | Bus data lanes |

## Verification
The assertions assume that `cfg_mode` and the three timing inputs change only while `bus_cs_n` is high, because the engine samples them as each word and phase begins. They also assume the host keeps `in_word`, `in_cmd` and `in_last` steady while `in_valid` is high. The stimulus changes configuration only after a transaction has drained and chip select is back high. It drives words in the half cycle after a falling edge and drops `in_valid` right after the handshake edge. Invalid mode codes are held only while no transaction is open.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int BUS_W = 16;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_ACTIVE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_GAP    = 3'd4
    } phase_e;

    typedef enum logic {
        STY_WSTRB = 1'b0,
        STY_ENSTRB = 1'b1
    } style_e;

    typedef enum logic [1:0] {
        WD_8  = 2'd0,
        WD_9  = 2'd1,
        WD_16 = 2'd2
    } width_e;

    typedef enum logic [1:0] {
        TS_SETUP = 2'd0,
        TS_PULSE = 2'd1,
        TS_HOLD  = 2'd2
    } tsel_e;

    typedef struct packed {
        logic   ok;
        style_e style;
        width_e width;
    } mode_t;

    typedef struct packed {
        logic [BUS_W-1:0] data;
        logic             dc;
        logic             last;
    } word_t;

    function automatic mode_t decode_mode(input logic [3:0] code);
        mode_t m;
        m.ok    = 1'b1;
        m.style = STY_WSTRB;
        m.width = WD_16;
        case (code)
            4'h3: begin m.style = STY_ENSTRB; m.width = WD_16; end
            4'h4: begin m.style = STY_ENSTRB; m.width = WD_9;  end
            4'h5: begin m.style = STY_ENSTRB; m.width = WD_8;  end
            4'h6: begin m.style = STY_WSTRB;  m.width = WD_16; end
            4'h7: begin m.style = STY_WSTRB;  m.width = WD_9;  end
            4'h8: begin m.style = STY_WSTRB;  m.width = WD_8;  end
            default: m.ok = 1'b0;
        endcase
        return m;
    endfunction

    function automatic logic lane_used(input int lane, input width_e w);
        return (lane < 8) || (lane == 8 && w != WD_8) || (w == WD_16);
    endfunction

endpackage

// File: rtl/pbus_phase_timer.sv
module pbus_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  logic   mode_ok,
    input  logic   last_q,
    input  logic   tmr_done,
    output phase_e phase,
    output logic   in_ready,
    output logic   accept,
    output logic   tmr_load,
    output tsel_e  tsel
);
    phase_e nxt;

    assign in_ready = mode_ok && (phase == PH_IDLE || phase == PH_GAP);
    assign accept   = in_valid && in_ready;

    always_comb begin
        nxt      = phase;
        tmr_load = 1'b0;
        tsel     = TS_SETUP;
        case (phase)
            PH_IDLE, PH_GAP: begin
                if (accept) begin
                    nxt      = PH_SETUP;
                    tmr_load = 1'b1;
                    tsel     = TS_SETUP;
                end
            end
            PH_SETUP: begin
                if (tmr_done) begin
                    nxt      = PH_ACTIVE;
                    tmr_load = 1'b1;
                    tsel     = TS_PULSE;
                end
            end
            PH_ACTIVE: begin
                if (tmr_done) begin
                    nxt      = PH_HOLD;
                    tmr_load = 1'b1;
                    tsel     = TS_HOLD;
                end
            end
            PH_HOLD: begin
                if (tmr_done) begin
                    nxt = last_q ? PH_IDLE : PH_GAP;
                end
            end
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end
endmodule

// File: rtl/pbus_pin_drive.sv
module pbus_pin_drive
    import pbus_pkg::*;
(
    input  phase_e           phase,
    input  style_e           style,
    input  width_e           width,
    input  word_t            word_q,
    output logic             bus_cs_n,
    output logic             bus_dc,
    output logic             bus_ctl_a,
    output logic             bus_ctl_b,
    output logic [BUS_W-1:0] bus_data
);
    logic strobe_on;

    assign strobe_on = (phase == PH_ACTIVE);
    assign bus_cs_n  = (phase == PH_IDLE);
    assign bus_dc    = word_q.dc;
    // write-strobe bus: ctl_a = active-low write, ctl_b = idle read line
    // enable-strobe bus: ctl_a = read/write select, ctl_b = enable
    assign bus_ctl_a = (style == STY_WSTRB) ? !strobe_on : bus_cs_n;
    assign bus_ctl_b = (style == STY_WSTRB) ? 1'b1       : strobe_on;

    for (genvar i = 0; i < BUS_W; i++) begin : g_lane
        assign bus_data[i] = word_q.data[i] & lane_used(i, width);
    end
endmodule

// File: rtl/pbus_wr_engine.sv
module pbus_wr_engine
    import pbus_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       cfg_mode,
    input  logic [TW-1:0]    cfg_setup,
    input  logic [TW-1:0]    cfg_pulse,
    input  logic [TW-1:0]    cfg_hold,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_cmd,
    input  logic             in_last,
    input  logic [BUS_W-1:0] in_word,
    output logic             bus_cs_n,
    output logic             bus_dc,
    output logic             bus_ctl_a,
    output logic             bus_ctl_b,
    output logic [BUS_W-1:0] bus_data
);
    mode_t         mode_now;
    phase_e        phase;
    style_e        style_q;
    width_e        width_q;
    word_t         word_q;
    logic          accept;
    logic          tmr_load;
    logic          tmr_done;
    tsel_e         tsel;
    logic [TW-1:0] tmr_val;

    assign mode_now = decode_mode(cfg_mode);

    always_comb begin
        case (tsel)
            TS_PULSE: tmr_val = cfg_pulse;
            TS_HOLD:  tmr_val = cfg_hold;
            default:  tmr_val = cfg_setup;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            style_q     <= STY_WSTRB;
            width_q     <= WD_16;
            word_q.data <= '0;
            word_q.dc   <= 1'b1;
            word_q.last <= 1'b0;
        end else if (accept) begin
            style_q     <= mode_now.style;
            width_q     <= mode_now.width;
            word_q.data <= in_word;
            word_q.dc   <= !in_cmd;
            word_q.last <= in_last;
        end
    end

    pbus_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .mode_ok  (mode_now.ok),
        .last_q   (word_q.last),
        .tmr_done (tmr_done),
        .phase    (phase),
        .in_ready (in_ready),
        .accept   (accept),
        .tmr_load (tmr_load),
        .tsel     (tsel)
    );

    pbus_phase_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    pbus_pin_drive u_pins (
        .phase     (phase),
        .style     (style_q),
        .width     (width_q),
        .word_q    (word_q),
        .bus_cs_n  (bus_cs_n),
        .bus_dc    (bus_dc),
        .bus_ctl_a (bus_ctl_a),
        .bus_ctl_b (bus_ctl_b),
        .bus_data  (bus_data)
    );
endmodule

// File: rtl/pbus_wr_checker.sv
module pbus_wr_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        is_wstrb,
    input logic [1:0]  width_code,
    input logic        bus_cs_n,
    input logic        bus_ctl_a,
    input logic        bus_ctl_b,
    input logic [15:0] bus_data
);
    logic strobe_act;
    assign strobe_act = is_wstrb ? !bus_ctl_a : bus_ctl_b;

    // R6: a strobe never fires with chip select released
    a_r6_strobe_inside_cs: assert property (@(posedge clk) disable iff (rst)
        strobe_act |-> !bus_cs_n);

    // R4: read line idle on the write-strobe bus
    a_r4_read_idle: assert property (@(posedge clk) disable iff (rst)
        is_wstrb |-> bus_ctl_b);

    // R5: read/write select at write while selected
    a_r5_rw_at_write: assert property (@(posedge clk) disable iff (rst)
        (!is_wstrb && !bus_cs_n) |-> !bus_ctl_a);

    // R7: data steady while a word is in flight
    a_r7_data_steady: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && $past(!in_ready) && !bus_cs_n) |-> $stable(bus_data));

    // R8: unused upper lanes low
    a_r8_upper_low: assert property (@(posedge clk) disable iff (rst)
        (width_code != pbus_pkg::WD_16) |-> (bus_data[15:9] == 7'd0));

    // R9: handshake opens a word and closes the ready window
    a_r9_one_word: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (!in_ready && !bus_cs_n));
endmodule

bind pbus_wr_engine pbus_wr_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .is_wstrb   (style_q == pbus_pkg::STY_WSTRB),
    .width_code (width_q),
    .bus_cs_n   (bus_cs_n),
    .bus_ctl_a  (bus_ctl_a),
    .bus_ctl_b  (bus_ctl_b),
    .bus_data   (bus_data)
);

// File: tb/tb_pbus_wr_engine.sv
module tb_pbus_wr_engine;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    cfg_mode = 4'h6;
    logic [TW-1:0] cfg_setup = '0;
    logic [TW-1:0] cfg_pulse = '0;
    logic [TW-1:0] cfg_hold = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          in_cmd = 1'b0;
    logic          in_last = 1'b0;
    logic [15:0]   in_word = '0;
    logic          bus_cs_n, bus_dc, bus_ctl_a, bus_ctl_b;
    logic [15:0]   bus_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbus_wr_engine #(.TW(TW)) dut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_setup(cfg_setup),
        .cfg_pulse(cfg_pulse), .cfg_hold(cfg_hold), .in_valid(in_valid),
        .in_ready(in_ready), .in_cmd(in_cmd), .in_last(in_last),
        .in_word(in_word), .bus_cs_n(bus_cs_n), .bus_dc(bus_dc),
        .bus_ctl_a(bus_ctl_a), .bus_ctl_b(bus_ctl_b), .bus_data(bus_data)
    );

    typedef struct {
        logic [15:0] data;
        logic        dc;
        logic        wstrb;
        int          su;
        int          pw;
        int          hd;
        logic        last;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int n_chk = 0;
    int n_fail = 0;
    int mstate = 0;   // 0 wait, 1 setup, 2 active, 3 hold
    int cnt = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic logic [15:0] expect_mask(input logic [3:0] m, input logic [15:0] w);
        if (m == 4'h3 || m == 4'h6) return w;
        if (m == 4'h4 || m == 4'h7) return {7'd0, w[8:0]};
        return {8'd0, w[7:0]};
    endfunction

    // monitor: pops an expected item at each handshake and follows its phases
    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic act;
            act = cur.wstrb ? !bus_ctl_a : bus_ctl_b;
            if (mstate == 1) begin
                if (act) begin
                    chk(cnt == cur.su + 1, "R7 setup cycles", cnt, cur.su + 1);
                    chk(bus_data == cur.data, "R8 data lanes", bus_data, cur.data);
                    chk(bus_dc == cur.dc, "R3 dc level", bus_dc, cur.dc);
                    chk(!bus_cs_n, "R6 cs low during strobe", bus_cs_n, 0);
                    if (cur.wstrb) chk(bus_ctl_b, "R4 read line high", bus_ctl_b, 1);
                    else           chk(!bus_ctl_a, "R5 rw select low", bus_ctl_a, 0);
                    mstate = 2; cnt = 1;
                end else begin
                    cnt++;
                end
            end else if (mstate == 2) begin
                if (act) cnt++;
                else begin
                    chk(cnt == cur.pw + 1, cur.wstrb ? "R4 strobe width" : "R5 enable width", cnt, cur.pw + 1);
                    chk(bus_data == cur.data, "R7 data held after strobe", bus_data, cur.data);
                    mstate = 3; cnt = 1;
                end
            end else if (mstate == 3) begin
                if (!in_ready) cnt++;
                else begin
                    chk(cnt == cur.hd + 1, "R9 ready low through hold", cnt, cur.hd + 1);
                    chk(bus_cs_n == cur.last, "R6 cs after word", bus_cs_n, cur.last);
                    mstate = 0;
                end
            end
            if (mstate == 0 && in_valid && in_ready) begin
                if (q.size() == 0) chk(1'b0, "R9 unexpected handshake", 1, 0);
                else begin
                    cur = q.pop_front();
                    mstate = 1; cnt = 0;
                end
            end
        end
    end

    task automatic send(input bit cmd, input logic [15:0] w, input bit last);
        exp_t e;
        e.data  = expect_mask(cfg_mode, w);
        e.dc    = !cmd;
        e.wstrb = (cfg_mode >= 4'h6);
        e.su    = int'(cfg_setup);
        e.pw    = int'(cfg_pulse);
        e.hd    = int'(cfg_hold);
        e.last  = last;
        q.push_back(e);
        @(negedge clk); #1;
        in_valid = 1'b1; in_cmd = cmd; in_word = w; in_last = last;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0 || mstate != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [3:0] m, input int s, input int p, input int h);
        cfg_mode = m; cfg_setup = TW'(s); cfg_pulse = TW'(p); cfg_hold = TW'(h);
    endtask

    task automatic bad_mode(input logic [3:0] m);
        @(negedge clk); #1;
        cfg_mode = m; in_valid = 1'b1; in_word = 16'h1234; in_cmd = 1'b1; in_last = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(!in_ready, "R2 invalid code refused", in_ready, 0);
            chk(bus_cs_n, "R2 cs stays high", bus_cs_n, 1);
        end
        #1 in_valid = 1'b0; cfg_mode = 4'h6;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        wrap_up();
    end

    initial begin
        cur = '{default: '0};
        cur.wstrb = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(bus_cs_n == 1, "R1 cs idle in reset", bus_cs_n, 1);
        chk(bus_data == 0, "R1 data idle in reset", bus_data, 0);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(bus_cs_n && bus_ctl_a && bus_ctl_b, "R1 control idle", {bus_cs_n, bus_ctl_a, bus_ctl_b}, 3'b111);
        chk(bus_dc == 1, "R1 dc idle", bus_dc, 1);
        chk(in_ready == 1, "R1 ready after reset", in_ready, 1);

        // R4 write-strobe bus, 16 lanes
        set_cfg(4'h6, 1, 2, 0);
        send(1, 16'h002C, 0);
        send(0, 16'hBEEF, 0);
        send(0, 16'h8001, 0);
        send(0, 16'h7E55, 1);
        drain();

        // R8 narrow widths on write-strobe bus
        set_cfg(4'h8, 0, 0, 1);
        send(1, 16'hFF3A, 0);
        send(0, 16'hFFFF, 1);
        drain();
        set_cfg(4'h7, 2, 1, 2);
        send(1, 16'hABCD, 0);
        send(0, 16'h0F1F, 0);
        send(1, 16'h5A5A, 0);   // R3 command in the middle
        send(0, 16'hFFFF, 1);
        drain();

        // R5 enable-strobe bus at all widths
        set_cfg(4'h3, 0, 0, 3);
        send(1, 16'h2A2A, 0);
        send(0, 16'hC3A5, 1);
        drain();
        chk(bus_ctl_a == 1 && bus_ctl_b == 0, "R5 idle levels", {bus_ctl_a, bus_ctl_b}, 2'b10);
        set_cfg(4'h4, 3, 4, 0);
        send(1, 16'hFE01, 0);
        send(0, 16'h0300, 1);
        drain();
        set_cfg(4'h5, 1, 1, 1);
        send(1, 16'h1234, 1);   // R6 command-only transaction
        drain();
        chk(bus_cs_n == 1, "R6 cs released after lone command", bus_cs_n, 1);

        // R2 invalid codes
        bad_mode(4'h0);
        bad_mode(4'h1);
        bad_mode(4'h9);
        bad_mode(4'hF);

        // long timing values
        set_cfg(4'h6, 15, 15, 15);
        send(1, 16'h4321, 0);
        send(0, 16'hAAAA, 1);
        drain();

        wrap_up();
    end
endmodule